// File: doc/BRIEF.md
# System Clock Mode and Power Management Controller

This block holds the clock configuration of a small microcontroller and turns it into a clock-divide selection, an enable for the high-frequency oscillator and an enable for the core clock. Software writes a five-bit control word. That word holds a two-bit divider code, a power-management enable, a switchback enable and a stop request. The block decodes the word into one of six clock modes. Two of these are low-power modes: a divide-by-256 mode and a mode that runs from the 32 kHz source.

Switchback lets hardware leave low-power operation by itself. When switchback is enabled, any enabled I/O, alarm or debug event clears the power-management enable. The same events also block software from setting that enable while one of them is active. A stop request halts the core clock and the high-frequency oscillator. Only an external interrupt that was enabled when stop began, an RTC alarm, or a reset ends stop.

A sticky status word records which event caused a switchback or a stop exit. The interface uses plain level and strobe pins. The block carries no data stream, so it has no valid/ready handshake and no back-pressure.

Top module: `clkmode_ctl`

## Requirements
- R1: After reset the following values hold:
  - `ctrl_q` is 0, `div_sel` is 000 and `status` is 0.
  - `hf_osc_en` and `core_clk_en` are 1, and `pme_clr_pulse` is 0.
- R2: The layout of the control word is fixed:
  - Bits [1:0] are the divider code.
  - Bit 2 is the power-management enable and bit 3 is the switchback enable.
  - Bit 4 is the stop request.
  - A write with `wr_en` updates the word at the next clock edge, and `ctrl_q` returns it.
- R3: With the power-management enable at 0, divider codes 00, 01, 10 and 11 give `div_sel` 000, 001, 010 and 011 (divide by 1, 2, 4 and 8). With the enable at 1, codes 01 and 10 give the same values as with the enable at 0.
- R4: With the power-management enable at 1, divider code 00 gives `div_sel` 100 (divide by 256) and code 11 gives `div_sel` 101 (32 kHz source). Clearing the enable returns `div_sel` to 000 from the first mode and to 011 from the second.
- R5: In the 32 kHz mode, `hf_osc_en` is 0 when the switchback enable is 0 and 1 when it is 1.
- R6: When both the switchback enable and the power-management enable are 1, an enabled event clears the power-management enable at the clock edge where the event is seen. The same edge raises `pme_clr_pulse` for exactly one cycle, and the divider code is kept. Events whose enables are 0 have no effect. The events are:
  - an external interrupt,
  - a UART transmit write,
  - an SPI transmit write,
  - an RTC alarm,
  - entry into debug mode.
- R7: Falling edges on `uart_rxd` and `spi_ssel_n` count as switchback events once they pass a two-flop synchronizer:
  - a receive line counts only while its receiver is enabled;
  - the slave-select line counts only while `spi_slave` is 1.
- R8: Suppose software writes a word with both the switchback bit and the power-management bit set while a switchback source is active. The power-management enable then keeps its previous value. If the switchback bit is clear, the same write is not blocked.
- R9: Writing the stop bit drives `core_clk_en` and `hf_osc_en` to 0. While stop is set, writes are ignored, and the divider code and the switchback enable keep their values.
- R10: Stop is left, with the stop bit cleared and both enables back to 1, in two cases:
  - an external interrupt arrives whose enable was 1 at the write that entered stop;
  - an RTC alarm arrives.
  An interrupt that was enabled only after entry does not end stop.
- R11: `status` is sticky and each bit is cleared by a 1 on the matching `stat_clr` bit. The bit assignments are:
  - Switchback causes: bit 0 external interrupt, bit 1 UART receive edge, bit 2 UART transmit write, bit 3 SPI transmit write, bit 4 slave-select edge, bit 5 RTC alarm, bit 6 debug entry.
  - Stop exits: bit 7 by interrupt, bit 8 by RTC alarm.
- R12: A reset asserted during stop returns every control bit and every status bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running low-frequency clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 5 | Control word write value |
| ctrl_q | output | 5 | Current control word |
| stat_clr | input | 9 | Write-one-to-clear mask for status |
| status | output | 9 | Sticky cause bits |
| ext_irq | input | NUM_IRQ | External interrupt requests |
| irq_en | input | NUM_IRQ | External interrupt enables |
| uart_rxd | input | NUM_UART | Asynchronous UART receive lines |
| uart_rx_en | input | NUM_UART | UART receiver enables |
| uart_tx_wr | input | NUM_UART | UART transmit buffer write strobes |
| uart_tx_en | input | NUM_UART | UART transmitter enables |
| spi_tx_wr | input | 1 | SPI data register write strobe |
| spi_tx_en | input | 1 | SPI transmit enable |
| spi_ssel_n | input | 1 | Asynchronous SPI slave-select line |
| spi_slave | input | 1 | SPI configured as slave |
| rtc_alarm | input | 1 | RTC time-of-day alarm strobe |
| dbg_enter | input | 1 | Debug mode entry strobe |
| div_sel | output | 3 | Clock mode / divide selection |
| hf_osc_en | output | 1 | High-frequency oscillator enable |
| core_clk_en | output | 1 | Core clock enable (0 in stop) |
| pme_clr_pulse | output | 1 | One-cycle pulse on switchback clear |

## Verification
The first pattern steps through every divider code with the power-management enable at 0 and at 1. This separates the four plain divide modes from the two low-power modes. The switchback events are then applied one at a time, each once with its enable at 1 and once with its enable at 0. This shows that the enable bits are honoured and that the status bit for each cause is the right one. The stop tests use one interrupt that was enabled before entry and another that was enabled after entry. This separates the enable captured at entry from the live enable. Holding an interrupt active across a write checks that entry into power management is blocked only when the switchback bit is set.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
  localparam int CTRL_W  = 5;
  localparam int CB_PME  = 2;
  localparam int CB_SWB  = 3;
  localparam int CB_STOP = 4;

  // switchback cause indices
  localparam int SRC_IRQ  = 0;
  localparam int SRC_URX  = 1;
  localparam int SRC_UTX  = 2;
  localparam int SRC_STX  = 3;
  localparam int SRC_SSEL = 4;
  localparam int SRC_RTC  = 5;
  localparam int SRC_DBG  = 6;
  localparam int SB_NSRC  = 7;

  localparam int ST_WAKE_IRQ = SB_NSRC;
  localparam int ST_WAKE_RTC = SB_NSRC + 1;
  localparam int STAT_W      = SB_NSRC + 2;

  typedef enum logic [2:0] {
    DSEL_DIV1   = 3'd0,
    DSEL_DIV2   = 3'd1,
    DSEL_DIV4   = 3'd2,
    DSEL_DIV8   = 3'd3,
    DSEL_DIV256 = 3'd4,
    DSEL_LF32K  = 3'd5
  } dsel_e;
endpackage

// File: rtl/cm_edge_sync.sv
module cm_edge_sync #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din_n,
  output logic [W-1:0] fall
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, prev;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1   <= 1'b1;
        s2   <= 1'b1;
        prev <= 1'b1;
      end else begin
        s1   <= din_n[i];
        s2   <= s1;
        prev <= s2;
      end
    end
    assign fall[i] = prev & ~s2;
  end
endmodule

// File: rtl/cm_ctrl_core.sv
module cm_ctrl_core
  import clkmode_pkg::*;
#(
  parameter int NUM_IRQ = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CTRL_W-1:0]   wr_data,
  input  logic [SB_NSRC-1:0]  sb_src,
  input  logic [NUM_IRQ-1:0]  ext_irq,
  input  logic [NUM_IRQ-1:0]  irq_en,
  input  logic                rtc_alarm,
  output logic [1:0]          div_q,
  output logic                pme_q,
  output logic                swb_q,
  output logic                stop_q,
  output logic                sb_hit,
  output logic                wake_irq,
  output logic                wake_rtc,
  output logic                pme_clr_pulse
);
  logic [NUM_IRQ-1:0] irq_en_stop;
  logic src_any, wr_ok, set_block, pme_d;

  assign src_any   = |sb_src;
  assign sb_hit    = swb_q & pme_q & src_any;
  assign wr_ok     = wr_en & ~stop_q;
  assign set_block = wr_data[CB_SWB] & wr_data[CB_PME] & src_any;
  assign wake_irq  = stop_q & (|(ext_irq & irq_en_stop));
  assign wake_rtc  = stop_q & rtc_alarm;

  always_comb begin
    pme_d = pme_q;
    if (wr_ok) pme_d = set_block ? pme_q : wr_data[CB_PME];
    if (sb_hit) pme_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q         <= '0;
      pme_q         <= 1'b0;
      swb_q         <= 1'b0;
      stop_q        <= 1'b0;
      irq_en_stop   <= '0;
      pme_clr_pulse <= 1'b0;
    end else begin
      pme_q         <= pme_d;
      pme_clr_pulse <= sb_hit;
      if (wr_ok) begin
        div_q       <= wr_data[1:0];
        swb_q       <= wr_data[CB_SWB];
        stop_q      <= wr_data[CB_STOP];
        irq_en_stop <= irq_en;
      end else if (wake_irq || wake_rtc) begin
        stop_q <= 1'b0;
      end
    end
  end

  AST_SB_CLEARS_PME: assert property (@(posedge clk) disable iff (!rst_n)
    (swb_q && pme_q && (|sb_src)) |=> !pme_q); // R6
  AST_CLR_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pme_clr_pulse |=> !pme_clr_pulse); // R6
  AST_BLOCK_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !stop_q && wr_data[CB_SWB] && (|sb_src) && !pme_q) |=> !pme_q); // R8
  AST_STOP_KEEPS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    stop_q |=> ($stable(div_q) && $stable(swb_q))); // R9
  AST_RTC_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_q && rtc_alarm) |=> !stop_q); // R10
endmodule

// File: rtl/cm_mode_dec.sv
module cm_mode_dec
  import clkmode_pkg::*;
(
  input  logic [1:0] div_q,
  input  logic       pme_q,
  input  logic       swb_q,
  input  logic       stop_q,
  output dsel_e      dsel,
  output logic       hf_osc_en,
  output logic       core_clk_en
);
  always_comb begin
    unique case (div_q)
      2'b00:   dsel = pme_q ? DSEL_DIV256 : DSEL_DIV1;
      2'b01:   dsel = DSEL_DIV2;
      2'b10:   dsel = DSEL_DIV4;
      default: dsel = pme_q ? DSEL_LF32K : DSEL_DIV8;
    endcase
  end

  assign core_clk_en = ~stop_q;
  assign hf_osc_en   = ~stop_q & ~((dsel == DSEL_LF32K) & ~swb_q);
endmodule

// File: rtl/cm_status.sv
module cm_status
  import clkmode_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] set,
  input  logic [STAT_W-1:0] clr,
  output logic [STAT_W-1:0] status_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= (status_q & ~clr) | set;
  end

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~clr)) == $past(status_q & ~clr))); // R11
endmodule

// File: rtl/clkmode_ctl.sv
module clkmode_ctl
  import clkmode_pkg::*;
#(
  parameter int NUM_IRQ  = 4,
  parameter int NUM_UART = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [4:0]          wr_data,
  output logic [4:0]          ctrl_q,
  input  logic [8:0]          stat_clr,
  output logic [8:0]          status,
  input  logic [NUM_IRQ-1:0]  ext_irq,
  input  logic [NUM_IRQ-1:0]  irq_en,
  input  logic [NUM_UART-1:0] uart_rxd,
  input  logic [NUM_UART-1:0] uart_rx_en,
  input  logic [NUM_UART-1:0] uart_tx_wr,
  input  logic [NUM_UART-1:0] uart_tx_en,
  input  logic                spi_tx_wr,
  input  logic                spi_tx_en,
  input  logic                spi_ssel_n,
  input  logic                spi_slave,
  input  logic                rtc_alarm,
  input  logic                dbg_enter,
  output logic [2:0]          div_sel,
  output logic                hf_osc_en,
  output logic                core_clk_en,
  output logic                pme_clr_pulse
);
  localparam int NSYNC = NUM_UART + 1;

  logic [NSYNC-1:0]   fall;
  logic [SB_NSRC-1:0] sb_src;
  logic [STAT_W-1:0]  stat_set;
  logic [1:0]         div_q;
  logic               pme_q, swb_q, stop_q, sb_hit, wake_irq, wake_rtc;
  dsel_e              dsel;

  cm_edge_sync #(.W(NSYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din_n ({spi_ssel_n, uart_rxd}),
    .fall  (fall)
  );

  always_comb begin
    sb_src           = '0;
    sb_src[SRC_IRQ]  = |(ext_irq & irq_en);
    sb_src[SRC_URX]  = |(fall[NUM_UART-1:0] & uart_rx_en);
    sb_src[SRC_UTX]  = |(uart_tx_wr & uart_tx_en);
    sb_src[SRC_STX]  = spi_tx_wr & spi_tx_en;
    sb_src[SRC_SSEL] = fall[NUM_UART] & spi_slave;
    sb_src[SRC_RTC]  = rtc_alarm;
    sb_src[SRC_DBG]  = dbg_enter;
  end

  cm_ctrl_core #(.NUM_IRQ(NUM_IRQ)) u_core (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_data       (wr_data),
    .sb_src        (sb_src),
    .ext_irq       (ext_irq),
    .irq_en        (irq_en),
    .rtc_alarm     (rtc_alarm),
    .div_q         (div_q),
    .pme_q         (pme_q),
    .swb_q         (swb_q),
    .stop_q        (stop_q),
    .sb_hit        (sb_hit),
    .wake_irq      (wake_irq),
    .wake_rtc      (wake_rtc),
    .pme_clr_pulse (pme_clr_pulse)
  );

  cm_mode_dec u_dec (
    .div_q       (div_q),
    .pme_q       (pme_q),
    .swb_q       (swb_q),
    .stop_q      (stop_q),
    .dsel        (dsel),
    .hf_osc_en   (hf_osc_en),
    .core_clk_en (core_clk_en)
  );

  assign stat_set = {wake_rtc, wake_irq, sb_src & {SB_NSRC{sb_hit}}};

  cm_status u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .set      (stat_set),
    .clr      (stat_clr),
    .status_q (status)
  );

  assign ctrl_q  = {stop_q, swb_q, pme_q, div_q};
  assign div_sel = dsel;

  AST_LF_OSC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (div_sel == DSEL_LF32K && !ctrl_q[CB_SWB]) |-> !hf_osc_en); // R5
  AST_STOP_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ctrl_q[CB_STOP] && wr_data[CB_STOP]) |=> (!core_clk_en && !hf_osc_en)); // R9
endmodule

// File: tb/clkmode_ctl_tb.sv
module clkmode_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NU = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [4:0] ctrl_q;
  logic [8:0] stat_clr = '0;
  logic [8:0] status;
  logic [NI-1:0] ext_irq = '0, irq_en = '0;
  logic [NU-1:0] uart_rxd = '1, uart_rx_en = '0, uart_tx_wr = '0, uart_tx_en = '0;
  logic spi_tx_wr = 0, spi_tx_en = 0, spi_ssel_n = 1, spi_slave = 0;
  logic rtc_alarm = 0, dbg_enter = 0;
  logic [2:0] div_sel;
  logic hf_osc_en, core_clk_en, pme_clr_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkmode_ctl #(.NUM_IRQ(NI), .NUM_UART(NU)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .ctrl_q(ctrl_q),
    .stat_clr(stat_clr), .status(status), .ext_irq(ext_irq), .irq_en(irq_en),
    .uart_rxd(uart_rxd), .uart_rx_en(uart_rx_en), .uart_tx_wr(uart_tx_wr),
    .uart_tx_en(uart_tx_en), .spi_tx_wr(spi_tx_wr), .spi_tx_en(spi_tx_en),
    .spi_ssel_n(spi_ssel_n), .spi_slave(spi_slave), .rtc_alarm(rtc_alarm),
    .dbg_enter(dbg_enter), .div_sel(div_sel), .hf_osc_en(hf_osc_en),
    .core_clk_en(core_clk_en), .pme_clr_pulse(pme_clr_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [4:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr_stat();
    stat_clr = '1;
    @(negedge clk);
    stat_clr = '0;
  endtask

  task automatic t_reset();
    chk("R1 ctrl", ctrl_q, 0);
    chk("R1 div_sel", div_sel, 0);
    chk("R1 hf_osc_en", hf_osc_en, 1);
    chk("R1 core_clk_en", core_clk_en, 1);
    chk("R1 status", status, 0);
    chk("R1 pulse", pme_clr_pulse, 0);
  endtask

  task automatic t_regs();
    wr(5'b01001);
    chk("R2 readback swb+div01", ctrl_q, 5'b01001);
    wr(5'b00110);
    chk("R2 readback pme+div10", ctrl_q, 5'b00110);
    wr(5'b00000);
  endtask

  task automatic t_divcodes();
    for (int c = 0; c < 4; c++) begin
      wr({3'b000, 2'(c)});
      chk("R3 plain code", div_sel, c);
    end
    wr(5'b00101);
    chk("R3 pme code01", div_sel, 3'b001);
    wr(5'b00110);
    chk("R3 pme code10", div_sel, 3'b010);
  endtask

  task automatic t_pmm();
    wr(5'b00100);
    chk("R4 pmm1 div256", div_sel, 3'b100);
    wr(5'b00000);
    chk("R4 pmm1 exit div1", div_sel, 3'b000);
    wr(5'b00111);
    chk("R4 pmm2 32k", div_sel, 3'b101);
    chk("R5 osc off no swb", hf_osc_en, 0);
    wr(5'b01111);
    chk("R5 osc on with swb", hf_osc_en, 1);
    wr(5'b00011);
    chk("R4 pmm2 exit div8", div_sel, 3'b011);
    chk("R5 osc on after exit", hf_osc_en, 1);
  endtask

  task automatic t_switchback();
    clr_stat();
    uart_tx_en = 2'b10;
    wr(5'b01111);
    uart_tx_wr = 2'b10;
    @(negedge clk);
    uart_tx_wr = '0;
    chk("R6 tx clears pme", ctrl_q, 5'b01011);
    chk("R6 pulse high", pme_clr_pulse, 1);
    chk("R6 div kept", div_sel, 3'b011);
    chk("R11 status uart tx", status, 9'h004);
    @(negedge clk);
    chk("R6 pulse one cycle", pme_clr_pulse, 0);
    wr(5'b01111);
    spi_tx_en = 1'b0; spi_tx_wr = 1'b1;
    uart_tx_wr = 2'b01;
    @(negedge clk);
    spi_tx_wr = 1'b0; uart_tx_wr = '0;
    chk("R6 disabled sources ignored", ctrl_q, 5'b01111);
    chk("R6 no pulse when ignored", pme_clr_pulse, 0);
    dbg_enter = 1'b1;
    @(negedge clk);
    dbg_enter = 1'b0;
    chk("R6 debug clears pme", ctrl_q, 5'b01011);
    chk("R11 status debug", status, 9'h044);
    clr_stat();
    chk("R11 status cleared", status, 0);
    wr(5'b00000);
  endtask

  task automatic t_edges();
    uart_rx_en = 2'b01;
    wr(5'b01100);
    chk("R4 pmm1 with swb", div_sel, 3'b100);
    uart_rxd[0] = 1'b0;
    cyc(4);
    chk("R7 rx edge clears pme", ctrl_q, 5'b01000);
    chk("R11 status uart rx", status, 9'h002);
    uart_rxd[0] = 1'b1;
    cyc(4);
    clr_stat();
    spi_slave = 1'b0;
    wr(5'b01100);
    spi_ssel_n = 1'b0;
    cyc(4);
    chk("R7 ssel ignored in master", ctrl_q, 5'b01100);
    spi_ssel_n = 1'b1;
    cyc(4);
    spi_slave = 1'b1;
    spi_ssel_n = 1'b0;
    cyc(4);
    chk("R7 ssel edge in slave", ctrl_q, 5'b01000);
    chk("R11 status ssel", status, 9'h010);
    spi_ssel_n = 1'b1;
    spi_slave = 1'b0;
    cyc(4);
    clr_stat();
    wr(5'b00000);
  endtask

  task automatic t_block();
    irq_en = 4'b0001;
    ext_irq = 4'b0001;
    @(negedge clk);
    wr(5'b01100);
    chk("R8 entry blocked", ctrl_q, 5'b01000);
    wr(5'b00100);
    chk("R8 no block without swb", ctrl_q, 5'b00100);
    ext_irq = '0;
    wr(5'b00000);
    irq_en = '0;
    clr_stat();
  endtask

  task automatic t_stop();
    irq_en = 4'b0001;
    wr(5'b10011);
    chk("R9 core clock off", core_clk_en, 0);
    chk("R9 osc off", hf_osc_en, 0);
    wr(5'b00000);
    chk("R9 write ignored in stop", ctrl_q, 5'b10011);
    irq_en = 4'b0011;
    ext_irq = 4'b0010;
    @(negedge clk);
    ext_irq = '0;
    chk("R10 late-enabled irq no wake", ctrl_q, 5'b10011);
    ext_irq = 4'b0001;
    @(negedge clk);
    ext_irq = '0;
    chk("R10 irq wake", ctrl_q, 5'b00011);
    chk("R10 core clock on", core_clk_en, 1);
    chk("R10 osc on", hf_osc_en, 1);
    chk("R11 status stop irq", status, 9'h080);
    irq_en = '0;
    wr(5'b10001);
    rtc_alarm = 1'b1;
    @(negedge clk);
    rtc_alarm = 1'b0;
    chk("R10 rtc wake", ctrl_q, 5'b00001);
    chk("R11 status both wakes", status, 9'h180);
    stat_clr = 9'h080;
    @(negedge clk);
    stat_clr = '0;
    chk("R11 selective clear", status, 9'h100);
  endtask

  task automatic t_reset_stop();
    wr(5'b11110);
    rst_n = 1'b0;
    cyc(2);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 ctrl after reset", ctrl_q, 0);
    chk("R12 status after reset", status, 0);
    chk("R12 core clock on", core_clk_en, 1);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_divcodes();
    t_pmm();
    t_switchback();
    t_edges();
    t_block();
    t_stop();
    t_reset_stop();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule